// File: doc/BRIEF.md
# Modulo timer counter with overflow flag

This block is a free-running counter that wraps at a programmable modulo value. It has two counting modes. In the up mode it counts from zero to the modulo value and then returns to zero. In the up/down mode it climbs to the modulo value, descends to zero and climbs again, which suits center-aligned waveforms. A 2-bit source select chooses what advances the counter:
- nothing, which clears the counter;
- every bus clock cycle;
- rising edges of a fixed system clock input;
- rising edges of an external clock input.

The two slow clock inputs are resynchronized to the bus clock before their edges are detected.

Software works through a small register port with write and read strobes. A control/status register holds the overflow flag, the interrupt enable, the mode bit and the source select. The flag can only be cleared by a two-step handshake: a read that arms the clear, then a write of 0 to the flag bit. An overflow that lands between the read and the write cancels the clear. The interrupt output follows the flag gated by the enable.

Top module: `mod_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0, the modulo register reads 0, and irq_o is 0.
- R2: Source select field (control bits 1:0): 00 clears the counter and holds it at 0; 01 advances it once per bus clock cycle; 10 advances it once per rising edge of fix_clk_i; 11 advances it once per rising edge of ext_clk_i. Inputs that are not selected have no effect on the counter.
- R3: A rising edge on the selected slow clock input advances the counter exactly once, within three bus clock cycles of the edge, however long the input then stays high. The input must stay high and low for at least two bus cycles each.
- R4: With the mode bit (control bit 5) at 0, the counter steps 0, 1, ..., modulo, 0, and the overflow flag (control bit 7) sets on the step from the modulo value to 0.
- R5: With the mode bit at 1, the counter steps 0, 1, ..., modulo, modulo-1, ..., 0, 1, and so on. The overflow flag sets only on the step down from the modulo value, never at the turn at zero.
- R6: In up/down mode a modulo value of 0 holds the counter at 0 and raises no overflow.
- R7: A read of the control register while the flag is 1 arms a clear. The next control write with bit 7 at 0 then clears the flag. Any control write disarms the clear.
- R8: A control write with bit 7 at 1, or with bit 7 at 0 when no clear is armed, leaves the flag unchanged.
- R9: An overflow after the arming read and before the clearing write cancels the clear, so the flag stays 1 after that write.
- R10: irq_o is 1 exactly when the flag is 1 and the interrupt enable (control bit 6) is 1.
- R11: Register addresses: 0 is control/status, 1 is the counter (read-only, writes ignored), 2 is the modulo value (read/write, effective at once). Reads return live contents combinationally while bus_rd_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External slow clock, asynchronous |
| fix_clk_i | input | 1 | Fixed system clock, asynchronous, slow |
| bus_addr_i | input | 2 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default 16-bit counter width. It programs modulo values of 0, 3 and 100. A modulo of 3 makes wraps, the turn at the top and the turn at the bottom occur within a handful of driven clock edges, so the flag handshake, its cancellation and both count directions can all be reached by counting pulses. The bus-clock source with modulo 100 shows per-cycle counting without a wrap, and modulo 0 reaches the degenerate hold case of the up/down mode.

// File: rtl/mod_timer.sv
`timescale 1ns/1ps
module mod_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             fix_clk_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_MOD  = 2'd2;
  localparam logic [1:0] S_OFF  = 2'd0;
  localparam logic [1:0] S_BUS  = 2'd1;
  localparam logic [1:0] S_FIX  = 2'd2;

  logic             ovf_flag, irq_en, center, dir_down, armed;
  logic [1:0]       src_sel;
  logic [CNT_W-1:0] cnt_q, mod_q, cnt_n;
  logic             down_n, ovf_evt;
  logic [2:0]       ext_s, fix_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s <= '0;
      fix_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk_i};
      fix_s <= {fix_s[1:0], fix_clk_i};
    end
  end

  wire ext_tick = ext_s[1] & ~ext_s[2];
  wire fix_tick = fix_s[1] & ~fix_s[2];
  wire tick = (src_sel == S_BUS) ? 1'b1 :
              (src_sel == S_FIX) ? fix_tick :
              (src_sel == S_OFF) ? 1'b0 : ext_tick;

  always_comb begin
    cnt_n   = cnt_q;
    down_n  = dir_down;
    ovf_evt = 1'b0;
    if (src_sel == S_OFF) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (tick) begin
      if (!center) begin
        down_n = 1'b0;
        if (cnt_q >= mod_q) begin
          cnt_n   = '0;
          ovf_evt = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end else if (mod_q == '0) begin
        cnt_n  = '0;
        down_n = 1'b0;
      end else if (!dir_down) begin
        if (cnt_q >= mod_q) begin
          cnt_n   = cnt_q - 1'b1;
          down_n  = 1'b1;
          ovf_evt = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end else if (cnt_q == '0) begin
        cnt_n  = {{(CNT_W-1){1'b0}}, 1'b1};
        down_n = 1'b0;
      end else cnt_n = cnt_q - 1'b1;
    end
  end

  wire ctrl_wr = bus_wr_i && bus_addr_i == A_CTRL;
  wire ctrl_rd = bus_rd_i && !bus_wr_i && bus_addr_i == A_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      mod_q    <= '0;
      dir_down <= 1'b0;
      ovf_flag <= 1'b0;
      irq_en   <= 1'b0;
      center   <= 1'b0;
      src_sel  <= S_OFF;
      armed    <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      dir_down <= down_n;
      if (bus_wr_i && bus_addr_i == A_MOD) mod_q <= bus_wdata_i;
      if (ctrl_wr) begin
        irq_en  <= bus_wdata_i[6];
        center  <= bus_wdata_i[5];
        src_sel <= bus_wdata_i[1:0];
      end
      if (ovf_evt) ovf_flag <= 1'b1;
      else if (ctrl_wr && armed && !bus_wdata_i[7]) ovf_flag <= 1'b0;
      if (ovf_evt || ctrl_wr) armed <= 1'b0;
      else if (ctrl_rd && ovf_flag) armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: bus_rdata_o[7:0] = {ovf_flag, irq_en, center, 3'b000, src_sel};
      A_CNT:  bus_rdata_o = cnt_q;
      A_MOD:  bus_rdata_o = mod_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = ovf_flag & irq_en;
endmodule

// File: rtl/mod_timer_chk.sv
`timescale 1ns/1ps
module mod_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr_i,
  input logic         bus_rd_i,
  input logic         bus_wr_i,
  input logic [W-1:0] bus_wdata_i,
  input logic [W-1:0] bus_rdata_o,
  input logic         irq_o,
  input logic         flag,
  input logic         armed,
  input logic         ovf,
  input logic [1:0]   sel,
  input logic         center,
  input logic [W-1:0] cnt,
  input logic [W-1:0] modv
);
  a_r10_irq_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 2'd0) |-> (irq_o == (bus_rdata_o[7] & bus_rdata_o[6])));

  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel == 2'd0) |-> cnt == '0);

  a_r7_arm_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(flag && bus_rd_i));

  a_r8_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && bus_wr_i && bus_addr_i == 2'd0 && !bus_wdata_i[7]));

  a_r9_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> flag);

  a_r5_single_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (center && $past(center) && sel != 2'd0 && $past(sel) != 2'd0 &&
     $stable(modv) && $past(cnt) <= modv)
    |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
endmodule

bind mod_timer mod_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i),
  .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .irq_o(irq_o), .flag(ovf_flag), .armed(armed), .ovf(ovf_evt), .sel(src_sel),
  .center(center), .cnt(cnt_q), .modv(mod_q)
);

// File: tb/test_mod_timer.sv
`timescale 1ns/1ps
module test_mod_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0, fix_clk = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_exp;
  string       m_tag;

  always #10 clk = ~clk;

  mod_timer i_mod_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .fix_clk_i(fix_clk),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    wr = 1'b0; rd = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic pulse(input bit on_fix, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
      if (on_fix) fix_clk = 1'b1; else ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      if (on_fix) fix_clk = 1'b0; else ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1 check(tag, {15'd0, irq}, {15'd0, e});
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n && rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 16'hFFFF, 16'h0000);
      else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        check(m_tag, rdata, m_exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(2'd0, 16'h0000, "R1 ctrl reset");
    rd_reg(2'd1, 16'h0000, "R1 counter reset");
    rd_reg(2'd2, 16'h0000, "R1 modulo reset");
    idle(); chk_irq(1'b0, "R1 irq reset");
    // R11 modulo live, R4 up counting on external edges
    wr_reg(2'd2, 16'd3);
    rd_reg(2'd2, 16'd3, "R11 modulo readback");
    wr_reg(2'd0, 16'h0003);
    pulse(1'b0, 3);
    rd_reg(2'd1, 16'd3, "R4 count reaches modulo");
    rd_reg(2'd0, 16'h0003, "R4 no flag before wrap");
    pulse(1'b0, 1);
    rd_reg(2'd1, 16'd0, "R4 wrap to zero");
    idle(); chk_irq(1'b0, "R10 irq masked by enable");
    rd_reg(2'd0, 16'h0083, "R4 flag set on wrap");
    // R8 write one, then unarmed write zero
    wr_reg(2'd0, 16'h00C3);
    chk_irq(1'b1, "R8 write one keeps flag / R10 irq");
    wr_reg(2'd0, 16'h0043);
    chk_irq(1'b1, "R8 unarmed write zero keeps flag");
    rd_reg(2'd0, 16'h00C3, "R8 flag still set");
    wr_reg(2'd0, 16'h0043);
    chk_irq(1'b0, "R7 armed clear drops irq");
    rd_reg(2'd0, 16'h0043, "R7 flag cleared");
    wr_reg(2'd1, 16'h0055);
    rd_reg(2'd1, 16'd0, "R11 counter write ignored");
    // R9 overflow between arm and clear
    pulse(1'b0, 4);
    rd_reg(2'd0, 16'h00C3, "R9 flag before arm");
    pulse(1'b0, 4);
    wr_reg(2'd0, 16'h0043);
    chk_irq(1'b1, "R9 clear cancelled");
    rd_reg(2'd0, 16'h00C3, "R9 flag survives");
    wr_reg(2'd0, 16'h0043);
    rd_reg(2'd0, 16'h0043, "R7 clear after rearm");
    // R2 off clears and ignores edges
    pulse(1'b0, 2);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd1, 16'd0, "R2 off clears counter");
    pulse(1'b0, 1);
    rd_reg(2'd1, 16'd0, "R2 off ignores edges");
    // R5 up/down
    wr_reg(2'd0, 16'h0023);
    pulse(1'b0, 3);
    rd_reg(2'd1, 16'd3, "R5 top reached");
    rd_reg(2'd0, 16'h0023, "R5 no flag at top");
    pulse(1'b0, 1);
    rd_reg(2'd1, 16'd2, "R5 step down");
    rd_reg(2'd0, 16'h00A3, "R5 flag on step down");
    wr_reg(2'd0, 16'h0023);
    pulse(1'b0, 2);
    rd_reg(2'd1, 16'd0, "R5 bottom reached");
    rd_reg(2'd0, 16'h0023, "R5 no flag at bottom");
    pulse(1'b0, 1);
    rd_reg(2'd1, 16'd1, "R5 turn at bottom");
    // R2/R3 fixed source
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, 16'h0002);
    pulse(1'b1, 1);
    rd_reg(2'd1, 16'd1, "R2 fixed source edge");
    pulse(1'b0, 1);
    rd_reg(2'd1, 16'd1, "R2 external ignored on fixed source");
    pulse(1'b1, 1);
    @(negedge clk);
    rd = 1'b0; fix_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_reg(2'd1, 16'd3, "R3 counted within three cycles");
    rd_reg(2'd1, 16'd3, "R3 held level counts once");
    repeat (3) idle();
    rd_reg(2'd1, 16'd3, "R3 still once");
    idle(); fix_clk = 1'b0;
    // R2 bus clock source
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd2, 16'd100);
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd1, 16'd1, "R2 bus cycle 1");
    rd_reg(2'd1, 16'd2, "R2 bus cycle 2");
    rd_reg(2'd1, 16'd3, "R2 bus cycle 3");
    // R6 modulo zero in up/down
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd2, 16'd0);
    wr_reg(2'd0, 16'h0021);
    repeat (5) idle();
    rd_reg(2'd1, 16'd0, "R6 held at zero");
    rd_reg(2'd0, 16'h0021, "R6 no overflow");
    repeat (3) idle();
    check("scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule